// File: doc/BRIEF.md
# Timer-Latch Fault Protection Unit

This block guards a six-rail power controller. Each rail supplies one comparator flag that reports whether its feedback sits beyond the rail's detection level. A seventh flag reports that the die is too hot. When any rail reports a fault, one shared delay counter starts. If a fault stays present for `TRIP_COUNT` consecutive clocks, a protection latch sets and forces every channel output off. An over-temperature flag sets the latch on the next clock without waiting for the counter.

The latch has only two release paths: the power-on reset, or the master shutdown input (the channel-1 enable, active low) being pulled low. Channel 5 can run as a boost converter or as an inverting converter. Its comparator sense flips with a topology-select input, so that a falling boost rail and a rising inverted rail both count as a fault. A status code records which source first caused the trip. It holds that code until the latch is released.

Top module: `fault_latch_unit`

## Requirements
- R1: After reset, `fault_latched` is 0, `kill_mask` is all zeros and `trip_src` is 0.
- R2: A channel fault held continuously sets `fault_latched` at the `TRIP_COUNT`-th rising edge after it appears, and not earlier. Once latched, `kill_mask` is all ones.
- R3: When no fault is present and the latch is clear, the counter returns to zero. A fault that starts again therefore needs a full `TRIP_COUNT` clocks.
- R4: For channel 5 (index 4), `topo_inv`=0 treats `uv_cmp[4]`=1 as the fault. `topo_inv`=1 treats `uv_cmp[4]`=0 as the fault. For every other channel, `uv_cmp[i]`=1 is the fault.
- R5: `ot_flag` high while `shdn1_n` is high sets `fault_latched` at the next rising edge.
- R6: Once set, the latch stays set after every fault input goes inactive, for as long as `shdn1_n` stays high.
- R7: `shdn1_n` low clears the latch and `trip_src` at the next edge. While `shdn1_n` is low, no fault can set the latch or advance the counter.
- R8: The `trip_src` coding is: channel index i maps to code i+1, and over-temperature maps to code 7. The code belongs to the channel that started the counter run. If several channels start in the same cycle, the lowest index wins. Over-temperature overrides a channel trip in the same cycle.
- R9: While latched, new faults, including over-temperature, leave `trip_src` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| shdn1_n | input | 1 | Master shutdown, active low; releases the latch |
| topo_inv | input | 1 | Channel 5 topology: 0 boost, 1 inverting |
| uv_cmp | input | NCH | Per-rail comparator results |
| ot_flag | input | 1 | Over-temperature flag |
| fault_latched | output | 1 | Protection latch state |
| kill_mask | output | NCH | Per-channel output-off mask |
| trip_src | output | SW | Code of the first trip cause |

## Verification
The hardest states to reach are the boundaries of a counter run: a fault that drops out one cycle before the trip, and a second source that joins a run already in progress. The bench reaches them with exact cycle counts. It drives the comparator inputs on falling edges and counts rising edges from the cycle a fault first appears. With a small `TRIP_COUNT`, it sweeps every channel, and channel 5 in both topologies. It also releases shutdown in the middle of a fault, so the counter run starts from a known edge.

// File: rtl/fl_pkg.sv
package fl_pkg;
  // Returns index+1 of the lowest active flag, or 0 when no flag is active.
  function automatic int unsigned first_src(input logic [31:0] flags, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (flags[i]) r = i + 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fl_fault_sense.sv
module fl_fault_sense #(
  parameter int NCH    = 6,
  parameter int INV_CH = 4
) (
  input  logic [NCH-1:0] uv_cmp,
  input  logic           topo_inv,
  output logic [NCH-1:0] ch_fault,
  output logic           any_ch_fault
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == INV_CH) begin : g_inv
      assign ch_fault[g] = uv_cmp[g] ^ topo_inv;
    end else begin : g_plain
      assign ch_fault[g] = uv_cmp[g];
    end
  end
  assign any_ch_fault = |ch_fault;
endmodule

// File: rtl/fl_delay_timer.sv
module fl_delay_timer
  import fl_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int TRIP_COUNT = 16,
  parameter int SW         = 3,
  localparam int CW = (TRIP_COUNT > 1) ? $clog2(TRIP_COUNT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic [NCH-1:0] ch_fault,
  input  logic           any_ch_fault,
  output logic [CW-1:0]  run_cnt,
  output logic           timer_done,
  output logic [SW-1:0]  run_src
);
  localparam logic [CW-1:0] LAST = CW'(TRIP_COUNT - 1);
  logic [SW-1:0] pend_src;
  logic [SW-1:0] now_src;
  logic          counting;

  assign counting   = run_en && any_ch_fault;
  assign now_src    = SW'(first_src(32'(ch_fault), NCH));
  assign timer_done = counting && (run_cnt == LAST);
  assign run_src    = (run_cnt == '0) ? now_src : pend_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      pend_src <= '0;
    end else if (!counting) begin
      run_cnt  <= '0;
    end else begin
      if (run_cnt == '0) pend_src <= now_src;
      if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fl_trip_latch.sv
module fl_trip_latch #(
  parameter int SW = 3,
  parameter int OT_CODE = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shdn1_n,
  input  logic          ot_flag,
  input  logic          timer_done,
  input  logic [SW-1:0] run_src,
  output logic          latched,
  output logic [SW-1:0] src_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      src_code <= '0;
    end else if (!shdn1_n) begin
      latched  <= 1'b0;
      src_code <= '0;
    end else if (!latched) begin
      if (ot_flag) begin
        latched  <= 1'b1;
        src_code <= SW'(OT_CODE);
      end else if (timer_done) begin
        latched  <= 1'b1;
        src_code <= run_src;
      end
    end
  end
endmodule

// File: rtl/fault_latch_unit.sv
module fault_latch_unit #(
  parameter int NCH        = 6,
  parameter int TRIP_COUNT = 16,
  parameter int INV_CH     = 4,
  localparam int SW = $clog2(NCH + 2),
  localparam int CW = (TRIP_COUNT > 1) ? $clog2(TRIP_COUNT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shdn1_n,
  input  logic           topo_inv,
  input  logic [NCH-1:0] uv_cmp,
  input  logic           ot_flag,
  output logic           fault_latched,
  output logic [NCH-1:0] kill_mask,
  output logic [SW-1:0]  trip_src
);
  logic [NCH-1:0] ch_fault;
  logic           any_fault;
  logic [CW-1:0]  run_cnt;
  logic           timer_done;
  logic [SW-1:0]  run_src;
  logic           run_en;

  assign run_en = shdn1_n && !fault_latched;

  fl_fault_sense #(.NCH(NCH), .INV_CH(INV_CH)) u_sense (
    .uv_cmp(uv_cmp), .topo_inv(topo_inv),
    .ch_fault(ch_fault), .any_ch_fault(any_fault)
  );

  fl_delay_timer #(.NCH(NCH), .TRIP_COUNT(TRIP_COUNT), .SW(SW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ch_fault(ch_fault),
    .any_ch_fault(any_fault), .run_cnt(run_cnt), .timer_done(timer_done),
    .run_src(run_src)
  );

  fl_trip_latch #(.SW(SW), .OT_CODE(NCH + 1)) u_latch (
    .clk(clk), .rst_n(rst_n), .shdn1_n(shdn1_n), .ot_flag(ot_flag),
    .timer_done(timer_done), .run_src(run_src),
    .latched(fault_latched), .src_code(trip_src)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_kill
    assign kill_mask[g] = fault_latched;
  end
endmodule

// File: rtl/fault_latch_unit_chk.sv
module fault_latch_unit_chk #(
  parameter int NCH = 6,
  parameter int SW  = 3,
  parameter int CW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shdn1_n,
  input logic          ot_flag,
  input logic          any_fault,
  input logic          timer_done,
  input logic [CW-1:0] run_cnt,
  input logic          fault_latched,
  input logic [SW-1:0] trip_src
);
  assert_trip_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> ($past(ot_flag) || $past(timer_done)));
  assert_timer_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_fault && !fault_latched) |=> (run_cnt == '0));
  assert_ot_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn1_n && ot_flag) |=> fault_latched);
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && shdn1_n) |=> fault_latched);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn1_n |=> (!fault_latched && trip_src == '0));
  assert_src_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (trip_src != '0));
  assert_src_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && shdn1_n) |=> $stable(trip_src));
endmodule

bind fault_latch_unit fault_latch_unit_chk #(.NCH(NCH), .SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn1_n(shdn1_n), .ot_flag(ot_flag),
  .any_fault(any_fault), .timer_done(timer_done), .run_cnt(run_cnt),
  .fault_latched(fault_latched), .trip_src(trip_src)
);

// File: tb/fault_latch_unit_tb.sv
module fault_latch_unit_tb;
  localparam int NCH = 6;
  localparam int TRIP = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn1_n = 1'b1;
  logic topo_inv = 1'b0;
  logic [NCH-1:0] uv_cmp = '0;
  logic ot_flag = 1'b0;
  logic fault_latched;
  logic [NCH-1:0] kill_mask;
  logic [SW-1:0] trip_src;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fault_latch_unit #(.NCH(NCH), .TRIP_COUNT(TRIP), .INV_CH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .shdn1_n(shdn1_n), .topo_inv(topo_inv),
    .uv_cmp(uv_cmp), .ot_flag(ot_flag), .fault_latched(fault_latched),
    .kill_mask(kill_mask), .trip_src(trip_src)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Healthy comparator vector: channel 5 idles high in inverting topology.
  function automatic logic [NCH-1:0] idle_vec(input logic inv);
    logic [NCH-1:0] v;
    v = '0;
    v[4] = inv;
    return v;
  endfunction

  function automatic logic [NCH-1:0] fault_vec(input logic inv, input int ch);
    logic [NCH-1:0] v;
    v = idle_vec(inv);
    v[ch] = ~v[ch];
    return v;
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_latch();
    uv_cmp = idle_vec(topo_inv);
    ot_flag = 1'b0;
    shdn1_n = 1'b0;
    ticks(1);
    check("R7 latch cleared", fault_latched, 0);
    check("R7 code cleared", trip_src, 0);
    shdn1_n = 1'b1;
    ticks(1);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ticks(2);
    check("R1 latch", fault_latched, 0);
    check("R1 mask", kill_mask, 0);
    check("R1 code", trip_src, 0);
    rst_n = 1'b1;
    ticks(2);

    // R2, R4, R8: sweep each channel in both channel-5 topologies.
    for (int t = 0; t < 2; t++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        topo_inv = t[0];
        uv_cmp = idle_vec(topo_inv);
        ticks(2);
        check("R4 idle no trip", fault_latched, 0);
        uv_cmp = fault_vec(topo_inv, ch);
        ticks(TRIP - 1);
        check("R2 not early", fault_latched, 0);
        ticks(1);
        check("R2 trip edge", fault_latched, 1);
        check("R2 mask all ones", kill_mask, (1 << NCH) - 1);
        check("R8 channel code", trip_src, ch + 1);
        uv_cmp = idle_vec(topo_inv);
        ticks(3);
        check("R6 stays latched", fault_latched, 1);
        release_latch();
      end
    end
    topo_inv = 1'b0;
    uv_cmp = '0;
    ticks(1);

    // R3: a one-cycle gap restarts the run.
    uv_cmp = fault_vec(0, 1);
    ticks(TRIP - 1);
    uv_cmp = '0;
    ticks(1);
    uv_cmp = fault_vec(0, 1);
    ticks(TRIP - 1);
    check("R3 restart not early", fault_latched, 0);
    ticks(1);
    check("R3 restart trip", fault_latched, 1);
    release_latch();

    // R8: simultaneous start, lowest index wins.
    uv_cmp = 6'b001100;
    ticks(TRIP);
    check("R8 simultaneous", trip_src, 3);
    release_latch();

    // R8: the starting channel keeps the code when a lower one joins.
    uv_cmp = 6'b100000;
    ticks(3);
    uv_cmp = 6'b100001;
    ticks(TRIP - 3);
    check("R8 run starter", trip_src, 6);
    release_latch();

    // R5: over-temperature trips on the next edge, mid-run.
    uv_cmp = 6'b000010;
    ticks(2);
    ot_flag = 1'b1;
    ticks(1);
    check("R5 ot latch", fault_latched, 1);
    check("R8 ot code", trip_src, 7);
    release_latch();

    // R8: over-temperature beats a channel trip in the same cycle.
    uv_cmp = 6'b000001;
    ticks(TRIP - 1);
    ot_flag = 1'b1;
    ticks(1);
    check("R8 ot priority", trip_src, 7);
    release_latch();

    // R9: faults after latching do not change the code.
    uv_cmp = 6'b000001;
    ticks(TRIP);
    ot_flag = 1'b1;
    uv_cmp = 6'b111111;
    ticks(3);
    check("R9 code frozen", trip_src, 1);
    release_latch();

    // R7: shutdown low blocks tripping; the run starts at release.
    shdn1_n = 1'b0;
    uv_cmp = 6'b000100;
    ot_flag = 1'b1;
    ticks(TRIP + 4);
    check("R7 blocked", fault_latched, 0);
    ot_flag = 1'b0;
    ticks(1);
    shdn1_n = 1'b1;
    ticks(TRIP - 1);
    check("R7 counter held at zero", fault_latched, 0);
    ticks(1);
    check("R7 trip after release", fault_latched, 1);
    release_latch();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule